// File: doc/BRIEF.md
# Edge-Sense Interrupt Unit

This block watches a bank of general-purpose input lines, sixteen by default, and requests service from a host processor when one of them changes in a chosen direction. Each line passes through a two-flop synchroniser. An edge detector then compares two successive synchronised samples. Each line has a 2-bit sense code that picks rising edges, falling edges, both, or none. Lines that see a selected edge set their bit in a sticky source register.

The interrupt request is an active-low output. It is driven low while any source bit is set for a line whose mask bit is 0. The host sees a new request as a falling edge on that output. The host reaches the sense, mask, source and control registers through a plain byte-wide register port. Source bits are cleared by writing ones to them. They are also cleared by reading them, unless a control bit switches read-clearing off.

Every multi-byte register is laid out high byte first: the lowest address of a register holds the highest-numbered lines. With the default of sixteen lines, the register addresses are:
- 0..3: sense
- 4..5: mask
- 6..7: source
- 8: control

Top module: `edge_irq_unit`

## Requirements
- R1: Line n's sense code is bits 2n+1:2n of the sense word. Code 01 latches a source bit on a rising edge of the line, code 10 on a falling edge, and code 11 on either edge.
- R2: Sense code 00 never sets the line's source bit, for either edge direction.
- R3: The sense word is stored high byte first. Address 0 holds bits 31:24 (lines 15..12) and address 3 holds bits 7:0 (lines 3..0). Within a byte, the higher line sits in the higher bit pair.
- R4: Mask bits sit at address 4 (bit k = line 8+k) and address 5 (bit k = line k). A set mask bit keeps its line from driving the request low, but the line's source bit is still latched.
- R5: Source bits sit at address 6 (lines 15..8) and address 7 (lines 7..0). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: With control bit 0 at 0, reading a source byte returns its current value and clears that byte, and only that byte, on the same clock edge.
- R7: The control register is address 8, bit 0. When that bit is 1, reads of the source bytes leave them unchanged.
- R8: `irq_no` is low exactly when some source bit is set for an unmasked line. It returns high once every such bit is cleared or masked.
- R9: An edge that sets a source bit in the same cycle as a clear of that bit (by write or by read) leaves the bit set.
- R10: An input change driven before clock edge k sets its source bit on edge k+2. `irq_no` therefore falls after the third rising clock edge, counting from the change.
- R11: After reset, sense and source read 0, control reads 0, both mask bytes read 0xFF, and `irq_no` is high.
- R12: Reads of addresses above 8 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 16 | Asynchronous input lines being watched |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Register write data |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| rd_en_i | input | 1 | Read strobe; drives clear-on-read |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench sweeps every sense code on every line in both edge directions. A detector that swaps the meaning of the two code bits, or that fires for code 00, shows up as a wrong source word. Byte order is checked by programming and unmasking lines through only one byte at a time. A design with the halves swapped would unmask or clear the wrong line.

Clear-on-read is checked on one byte while the other byte is still pending, which catches a clear that spills into the other byte. It is also checked with the control bit set. An edge is made to land in the same cycle as a write-one-to-clear. If the design gives the clear priority, the event is lost. The synchroniser latency is measured on the request output to the exact cycle.

// File: rtl/edge_irq_pkg.sv
`timescale 1ns/1ps
package edge_irq_pkg;

    // Per-line sense code; bit 0 arms rising, bit 1 arms falling.
    typedef enum logic [1:0] {
        SENSE_OFF  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/eiu_sync_edge.sv
`timescale 1ns/1ps
module eiu_sync_edge
    import edge_irq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [N-1:0]   lines_i,
    input  logic [2*N-1:0] sense_i,
    output logic [N-1:0]   edge_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.meta = lines_i;
        d.sync = q.meta;
        d.prev = q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    for (genvar n = 0; n < N; n++) begin : g_line
        sense_e code;
        logic   rise, fall;
        assign code = sense_e'(sense_i[2*n +: 2]);
        assign rise = q.sync[n] & ~q.prev[n];
        assign fall = ~q.sync[n] & q.prev[n];
        always_comb begin
            unique case (code)
                SENSE_RISE: edge_o[n] = rise;
                SENSE_FALL: edge_o[n] = fall;
                SENSE_BOTH: edge_o[n] = rise | fall;
                default:    edge_o[n] = 1'b0;
            endcase
        end
    end

    // Cycles since reset, saturating; lets the latency check look back safely.
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R10: an edge seen now was a change on the input pins two to three cycles back
    a_r10_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q == 2'd3 && (|edge_o)) |->
        ((edge_o & ~($past(lines_i, 2) ^ $past(lines_i, 3))) == '0));

endmodule

// File: rtl/eiu_regs.sv
`timescale 1ns/1ps
module eiu_regs
    import edge_irq_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [N-1:0]      src_i,
    output logic [2*N-1:0]    sense_o,
    output logic [N-1:0]      mask_o,
    output logic              noclr_o,
    output logic [N-1:0]      wclr_o,
    output logic [N-1:0]      rclr_o,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int LB        = N / BYTE_W;
    localparam int SB        = 2 * LB;
    localparam int MASK_BASE = SB;
    localparam int SRC_BASE  = SB + LB;
    localparam int CTRL_ADDR = SB + 2 * LB;

    if ((N % BYTE_W) != 0 || CTRL_ADDR >= (1 << AW)) begin : g_bad_cfg
        initial $fatal(1, "eiu_regs: N must be a multiple of 8 and fit the address width");
    end

    typedef struct packed {
        logic [2*N-1:0] sense;
        logic [N-1:0]   mask;
        logic           noclr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            for (int b = 0; b < SB; b++) begin
                if (addr_i == AW'(b)) d.sense[(SB-1-b)*BYTE_W +: BYTE_W] = wdata_i;
            end
            for (int b = 0; b < LB; b++) begin
                if (addr_i == AW'(MASK_BASE + b)) d.mask[(LB-1-b)*BYTE_W +: BYTE_W] = wdata_i;
            end
            if (addr_i == AW'(CTRL_ADDR)) d.noclr = wdata_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.sense <= '0;
            q.mask  <= '1;
            q.noclr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // Clear vectors for the source latch, one byte lane per address.
    always_comb begin
        wclr_o = '0;
        rclr_o = '0;
        for (int b = 0; b < LB; b++) begin
            if (addr_i == AW'(SRC_BASE + b)) begin
                if (wr_en_i)              wclr_o[(LB-1-b)*BYTE_W +: BYTE_W] = wdata_i;
                if (rd_en_i && !q.noclr)  rclr_o[(LB-1-b)*BYTE_W +: BYTE_W] = '1;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < SB; b++) begin
            if (addr_i == AW'(b)) rdata_o = q.sense[(SB-1-b)*BYTE_W +: BYTE_W];
        end
        for (int b = 0; b < LB; b++) begin
            if (addr_i == AW'(MASK_BASE + b)) rdata_o = q.mask[(LB-1-b)*BYTE_W +: BYTE_W];
            if (addr_i == AW'(SRC_BASE + b))  rdata_o = src_i[(LB-1-b)*BYTE_W +: BYTE_W];
        end
        if (addr_i == AW'(CTRL_ADDR)) rdata_o = {{(BYTE_W-1){1'b0}}, q.noclr};
    end

    assign sense_o = q.sense;
    assign mask_o  = q.mask;
    assign noclr_o = q.noclr;

endmodule

// File: rtl/eiu_source.sv
`timescale 1ns/1ps
module eiu_source #(
    parameter int N = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] src_o,
    output logic         irq_no
);

    typedef struct packed {
        logic [N-1:0] src;
    } src_t;

    src_t q, d;

    always_comb begin
        d     = q;
        d.src = (q.src & ~clr_i) | set_i;  // a fresh event outranks a clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign src_o  = q.src;
    assign irq_no = ~|(q.src & ~mask_i);

    // R1 / R9: every detected edge is recorded on the next edge, clear or not
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) |=> ((src_o & $past(set_i)) == $past(set_i)));

    // R5: a cleared bit with no concurrent event reads zero next cycle
    a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|clr_i) |=> ((src_o & $past(clr_i & ~set_i)) == '0));

    // R5: bits not being cleared are sticky
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(src_o) & ~$past(clr_i)) & ~src_o) == '0));

endmodule

// File: rtl/edge_irq_unit.sv
`timescale 1ns/1ps
module edge_irq_unit
    import edge_irq_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N-1:0]      lines_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              irq_no
);

    localparam int LB       = N / BYTE_W;
    localparam int SRC_BASE = 3 * LB;

    logic [2*N-1:0] sense_w;
    logic [N-1:0]   mask_w, edge_w, src_w, wclr_w, rclr_w;
    logic           noclr_w;

    eiu_sync_edge #(.N(N)) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lines_i (lines_i),
        .sense_i (sense_w),
        .edge_o  (edge_w)
    );

    eiu_regs #(.N(N), .AW(AW)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .src_i   (src_w),
        .sense_o (sense_w),
        .mask_o  (mask_w),
        .noclr_o (noclr_w),
        .wclr_o  (wclr_w),
        .rclr_o  (rclr_w),
        .rdata_o (rdata_o)
    );

    eiu_source #(.N(N)) u_src (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (edge_w),
        .clr_i  (wclr_w | rclr_w),
        .mask_i (mask_w),
        .src_o  (src_w),
        .irq_no (irq_no)
    );

    // Lines whose sense code is off, for the check below.
    logic [N-1:0] off_w;
    for (genvar n = 0; n < N; n++) begin : g_off
        assign off_w[n] = (sense_w[2*n +: 2] == 2'b00);
    end

    logic src_hit_w;
    assign src_hit_w = (addr_i >= AW'(SRC_BASE)) && (addr_i < AW'(SRC_BASE + LB));

    // R2: a line with sense off never gains a source bit
    a_r2_off_never_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((src_w & ~$past(src_w) & $past(off_w)) == '0));

    // R7: with read-clear disabled a read alone removes nothing
    a_r7_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !wr_en_i && src_hit_w && noclr_w) |=> (($past(src_w) & ~src_w) == '0));

    // R8: a new request always has an unmasked pending source behind it
    a_r8_fall_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_no) |-> ((src_w & ~mask_w) != '0));

endmodule

// File: tb/edge_irq_unit_tb_top.sv
`timescale 1ns/1ps
module edge_irq_unit_tb_top;

    localparam int N  = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lines = '0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rdata;
    logic          irq_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    edge_irq_unit #(.N(N), .AW(AW)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .lines_i (lines),
        .addr_i  (addr),
        .wdata_i (wdata),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .rdata_o (rdata),
        .irq_no  (irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_src(output logic [15:0] v);
        logic [7:0] hi, lo;
        rd(8'd6, hi);
        rd(8'd7, lo);
        v = {hi, lo};
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic fill_sense(input logic [1:0] code);
        for (int b = 0; b < 4; b++) wr(8'(b), {4{code}});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] s;
        logic [15:0] exp;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R11 reset state
        check("R11 irq high", 32'(irq_n), 32'd1);
        for (int a = 0; a < 4; a++) begin
            rd(8'(a), v); check("R11 sense zero", 32'(v), 32'h0);
        end
        rd(8'd4, v); check("R11 mask hi ones", 32'(v), 32'hFF);
        rd(8'd5, v); check("R11 mask lo ones", 32'(v), 32'hFF);
        rd_src(s);   check("R11 source zero", 32'(s), 32'h0);
        rd(8'd8, v); check("R11 ctrl zero", 32'(v), 32'h0);

        // R12 unmapped space
        wr(8'd9, 8'hA5);
        wr(8'd200, 8'h00);
        rd(8'd9, v);   check("R12 unmapped reads zero", 32'(v), 32'h0);
        rd(8'd4, v);   check("R12 mask untouched", 32'(v), 32'hFF);
        rd(8'd8, v);   check("R12 ctrl untouched", 32'(v), 32'h0);

        // R7 control bit, then unmask all for the sweep
        wr(8'd8, 8'h01);
        rd(8'd8, v); check("R7 ctrl readback", 32'(v), 32'h1);
        wr(8'd4, 8'h00);
        wr(8'd5, 8'h00);

        // R1 / R2 sweep: every code, every line, both directions
        for (int code = 0; code < 4; code++) begin
            fill_sense(2'(code));
            for (int ln = 0; ln < N; ln++) begin
                @(negedge clk); lines[ln] = 1'b1;
                idle(4);
                exp = code[0] ? 16'(1 << ln) : 16'h0;
                rd_src(s);
                check(code == 0 ? "R2 rise ignored" : "R1 rise", 32'(s), 32'(exp));
                check("R8 irq level after rise", 32'(irq_n), 32'(exp == 0));
                wr(8'd6, 8'hFF); wr(8'd7, 8'hFF);
                @(negedge clk); lines[ln] = 1'b0;
                idle(4);
                exp = code[1] ? 16'(1 << ln) : 16'h0;
                rd_src(s);
                check(code == 0 ? "R2 fall ignored" : "R1 fall", 32'(s), 32'(exp));
                wr(8'd6, 8'hFF); wr(8'd7, 8'hFF);
                check("R8 irq released", 32'(irq_n), 32'd1);
            end
        end

        // R10 latency on the request output
        fill_sense(2'b11);
        @(negedge clk); lines[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); check("R10 not yet after two edges", 32'(irq_n), 32'd1);
        @(negedge clk); check("R10 request after third edge", 32'(irq_n), 32'd0);
        wr(8'd7, 8'h08);
        check("R5 clear releases irq", 32'(irq_n), 32'd1);

        // R4 masking and mask byte order
        wr(8'd4, 8'hFF); wr(8'd5, 8'hFF);
        @(negedge clk); lines[9] = 1'b1;
        idle(4);
        check("R4 masked no irq", 32'(irq_n), 32'd1);
        rd_src(s); check("R4 masked still latches", 32'(s), 32'h0200);
        wr(8'd5, 8'hFD);
        check("R4 low byte is lines 7..0", 32'(irq_n), 32'd1);
        wr(8'd5, 8'hFF);
        wr(8'd4, 8'hFD);
        check("R4 unmask line 9 via high byte", 32'(irq_n), 32'd0);

        // R5 write-one-to-clear
        wr(8'd6, 8'h00);
        rd_src(s); check("R5 zero write no effect", 32'(s), 32'h0200);
        wr(8'd7, 8'hFF);
        rd_src(s); check("R5 other byte unaffected", 32'(s), 32'h0200);
        wr(8'd6, 8'h02);
        rd_src(s); check("R5 one clears", 32'(s), 32'h0);
        check("R8 irq high when cleared", 32'(irq_n), 32'd1);
        wr(8'd4, 8'h00); wr(8'd5, 8'h00);

        // R3 sense byte order
        wr(8'd0, 8'b0100_0000);
        wr(8'd1, 8'h00);
        wr(8'd2, 8'h00);
        wr(8'd3, 8'b0000_0010);
        @(negedge clk); lines = '1;
        idle(4);
        rd_src(s); check("R3 line 15 rise only", 32'(s), 32'h8000);
        wr(8'd6, 8'hFF);
        @(negedge clk); lines = '0;
        idle(4);
        rd_src(s); check("R3 line 0 fall only", 32'(s), 32'h0001);
        wr(8'd7, 8'hFF);

        // R6 clear-on-read, per byte
        fill_sense(2'b11);
        wr(8'd8, 8'h00);
        @(negedge clk); lines[2] = 1'b1; lines[10] = 1'b1;
        idle(4);
        rd(8'd7, v); check("R6 read returns value", 32'(v), 32'h04);
        rd(8'd7, v); check("R6 read cleared byte", 32'(v), 32'h00);
        check("R6 other byte still requests", 32'(irq_n), 32'd0);
        rd(8'd6, v); check("R6 high byte kept", 32'(v), 32'h04);
        rd(8'd6, v); check("R6 high byte cleared", 32'(v), 32'h00);
        check("R8 irq after read clear", 32'(irq_n), 32'd1);

        // R7 read-clear disabled
        wr(8'd8, 8'h01);
        @(negedge clk); lines[5] = 1'b1;
        idle(4);
        rd(8'd7, v); check("R7 first read", 32'(v), 32'h20);
        rd(8'd7, v); check("R7 read does not clear", 32'(v), 32'h20);
        check("R7 irq still low", 32'(irq_n), 32'd0);
        wr(8'd7, 8'h20);

        // R9 edge coincides with a clear write
        @(negedge clk); lines[4] = 1'b1;
        idle(4);
        rd_src(s); check("R9 setup", 32'(s), 32'h0010);
        @(negedge clk); lines[4] = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 8'd7; wdata = 8'h10; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        rd_src(s); check("R9 edge beats clear", 32'(s), 32'h0010);
        wr(8'd7, 8'h10);
        rd_src(s); check("R9 later clear works", 32'(s), 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule